// File: doc/BRIEF.md
# Cache-Line Address Monitor Wakeup Unit

This unit keeps the state behind one core's monitor-then-wait low-power sequence. Software first arms the monitor with a virtual address. A later wait request presents the physical address that translation produced for it. The unit trims that address down to the start of its cache line, remembers it, and enters the waiting state. From then on it compares every address on the incoming invalidation/snoop stream against the remembered line. An exact match ends the wait and sends the core a one-cycle wakeup pulse.

A wakeup that lands before the core asks to sleep is not lost. It leaves a pending flag, and the next wait request answers "do not sleep" at once and consumes that flag. In the cycle a wait request is presented, the unit gives its sleep/no-sleep answer combinationally. The unit also reports how many bytes of the armed line the armed virtual address covers: the span runs from that address up to the next line boundary. Translation, the cache and clock gating live elsewhere.

The snoop stream is a valid-only stream with no back-pressure. The unit examines every beat in the cycle it arrives and never stalls the stream. Arm and wait requests are single-cycle strobes.

Top module: `addr_monitor_wake`

## Requirements
- R1: During reset and directly after it, the unit is not armed and not waiting, no wakeup is pending, and `wake_o` is 0.
- R2: An arm strobe sets armed, stores `arm_vaddr_i` on `armed_vaddr_o` and sets the monitored line address `mon_line_o` to 0. The waiting state is left as it was.
- R3: A wait strobe with no wakeup pending stores `wait_paddr_i` with its low log2(LINE_BYTES) bits cleared (bits [5:0] at 64-byte lines) as the monitored line, and sets waiting.
- R4: A wait strobe while a wakeup is pending clears the pending flag. It leaves the monitored line and the waiting state unchanged.
- R5: A snoop beat wakes the core only when the unit is armed and waiting and `snoop_addr_i` equals the monitored line address in every bit.
- R6: A waking snoop clears waiting, sets the pending flag and drives `wake_o` high for exactly the one cycle after the beat.
- R7: A snoop beat that does not match, or that arrives while the unit is not armed or not waiting, changes no state and raises no wakeup.
- R8: Requests presented in the same cycle act in the order arm, then wait, then snoop. A snoop therefore compares against a line that an arm (0) or a wait stored in that same cycle.
- R9: `span_bytes_o` is LINE_BYTES minus the line offset of the armed virtual address, or LINE_BYTES when that offset is 0.
- R10: `wait_sleep_o` is 1 in a cycle with a wait strobe and no pending wakeup. It is 0 when a wakeup is pending or no wait strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid_i | input | 1 | Arm strobe |
| arm_vaddr_i | input | ADDR_W (48) | Virtual address to monitor |
| wait_valid_i | input | 1 | Wait strobe |
| wait_paddr_i | input | ADDR_W (48) | Translated physical address for the wait |
| wait_sleep_o | output | 1 | Same-cycle answer: 1 = sleep, 0 = return at once |
| snoop_valid_i | input | 1 | Snoop beat valid (always accepted) |
| snoop_addr_i | input | ADDR_W (48) | Invalidation line address |
| wake_o | output | 1 | One-cycle wakeup pulse |
| armed_o | output | 1 | Armed status |
| waiting_o | output | 1 | Waiting status |
| mon_line_o | output | ADDR_W (48) | Monitored line address |
| armed_vaddr_o | output | ADDR_W (48) | Stored armed virtual address |
| span_bytes_o | output | log2(LINE_BYTES)+1 (7) | Bytes from the armed address up to the next line boundary |

## Verification
A pending flag that is wrong stays hidden until the next wait strobe. That strobe then gives the wrong `wait_sleep_o` in the same cycle, so the stimulus places a wait after each wakeup. A corrupted line address shows up as a missed or spurious `wake_o` one cycle after a snoop beat, and also directly on `mon_line_o`. The same-cycle ordering cases and the snoop that matches a line an arm has just cleared to zero show whether arm, wait and snoop are applied in the right order.

// File: rtl/amon_pkg.sv
package amon_pkg;
  typedef struct packed {
    logic armed;
    logic waiting;
    logic pending;
  } amon_flags_t;
endpackage

// File: rtl/amon_align.sv
module amon_align #(
  parameter int ADDR_W     = 48,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SPAN_W    = OFF_W + 1
) (
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [OFF_W-1:0]  voff_i,
  output logic [ADDR_W-1:0] line_o,
  output logic [SPAN_W-1:0] span_o
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));
  localparam logic [SPAN_W-1:0] FULL_SPAN = SPAN_W'(LINE_BYTES);

  assign line_o = paddr_i & LINE_MASK;

  // span is cut at the next line boundary when the start is unaligned
  always_comb begin
    if (voff_i == '0) span_o = FULL_SPAN;
    else              span_o = FULL_SPAN - SPAN_W'(voff_i);
  end
endmodule

// File: rtl/amon_match.sv
module amon_match #(
  parameter int ADDR_W = 48
) (
  input  logic              valid_i,
  input  logic              armed_i,
  input  logic              waiting_i,
  input  logic [ADDR_W-1:0] line_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  assign hit_o = valid_i & armed_i & waiting_i & (addr_i == line_i);
endmodule

// File: rtl/amon_state.sv
module amon_state
  import amon_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_v_i,
  input  logic [ADDR_W-1:0] arm_vaddr_i,
  input  logic              wait_v_i,
  input  logic [ADDR_W-1:0] wait_line_i,
  input  logic              snoop_v_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              hit_i,
  output logic              eff_armed_o,
  output logic              eff_waiting_o,
  output logic [ADDR_W-1:0] eff_line_o,
  output amon_flags_t       flags_o,
  output logic [ADDR_W-1:0] line_o,
  output logic [ADDR_W-1:0] vaddr_o,
  output logic              wake_o,
  output logic              sleep_o
);
  amon_flags_t       flags_q;
  logic [ADDR_W-1:0] line_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic              wake_q;
  logic              wait_takes;

  // arm first, then wait, then snoop in the same cycle
  assign wait_takes    = wait_v_i & ~flags_q.pending;
  assign eff_armed_o   = flags_q.armed | arm_v_i;
  assign eff_waiting_o = flags_q.waiting | wait_takes;
  always_comb begin
    eff_line_o = line_q;
    if (arm_v_i)    eff_line_o = '0;
    if (wait_takes) eff_line_o = wait_line_i;
  end
  assign sleep_o = wait_takes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      line_q  <= '0;
      vaddr_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      flags_q.armed   <= eff_armed_o;
      flags_q.waiting <= eff_waiting_o & ~hit_i;
      flags_q.pending <= (flags_q.pending & ~wait_v_i) | hit_i;
      line_q          <= eff_line_o;
      if (arm_v_i) vaddr_q <= arm_vaddr_i;
      wake_q          <= hit_i;
    end
  end

  assign flags_o = flags_q;
  assign line_o  = line_q;
  assign vaddr_o = vaddr_q;
  assign wake_o  = wake_q;

  assert_arm_clears_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_v_i && !wait_v_i) |=> (flags_q.armed && line_q == '0 && vaddr_q == $past(arm_vaddr_i)));

  assert_wait_stores_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_v_i && !flags_q.pending) |=> (line_q == $past(wait_line_i)));

  assert_pending_wait_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_v_i && flags_q.pending && !arm_v_i && !snoop_v_i)
      |=> (!flags_q.pending && $stable(line_q) && $stable(flags_q.waiting)));

  assert_wake_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);

  assert_wake_ends_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (!flags_q.waiting && flags_q.pending));

  assert_miss_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_v_i && !arm_v_i && !wait_v_i && snoop_addr_i != line_q)
      |=> (!wake_q && $stable(flags_q)));

  assert_idle_no_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_v_i |-> !sleep_o);
endmodule

// File: rtl/addr_monitor_wake.sv
module addr_monitor_wake
  import amon_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SPAN_W    = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_valid_i,
  input  logic [ADDR_W-1:0] arm_vaddr_i,
  input  logic              wait_valid_i,
  input  logic [ADDR_W-1:0] wait_paddr_i,
  output logic              wait_sleep_o,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              wake_o,
  output logic              armed_o,
  output logic              waiting_o,
  output logic [ADDR_W-1:0] mon_line_o,
  output logic [ADDR_W-1:0] armed_vaddr_o,
  output logic [SPAN_W-1:0] span_bytes_o
);
  logic [ADDR_W-1:0] wait_line;
  logic [ADDR_W-1:0] eff_line;
  logic              eff_armed;
  logic              eff_waiting;
  logic              hit;
  amon_flags_t       flags;

  amon_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .paddr_i (wait_paddr_i),
    .voff_i  (armed_vaddr_o[OFF_W-1:0]),
    .line_o  (wait_line),
    .span_o  (span_bytes_o)
  );

  amon_match #(.ADDR_W(ADDR_W)) u_match (
    .valid_i   (snoop_valid_i),
    .armed_i   (eff_armed),
    .waiting_i (eff_waiting),
    .line_i    (eff_line),
    .addr_i    (snoop_addr_i),
    .hit_o     (hit)
  );

  amon_state #(.ADDR_W(ADDR_W)) u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm_v_i       (arm_valid_i),
    .arm_vaddr_i   (arm_vaddr_i),
    .wait_v_i      (wait_valid_i),
    .wait_line_i   (wait_line),
    .snoop_v_i     (snoop_valid_i),
    .snoop_addr_i  (snoop_addr_i),
    .hit_i         (hit),
    .eff_armed_o   (eff_armed),
    .eff_waiting_o (eff_waiting),
    .eff_line_o    (eff_line),
    .flags_o       (flags),
    .line_o        (mon_line_o),
    .vaddr_o       (armed_vaddr_o),
    .wake_o        (wake_o),
    .sleep_o       (wait_sleep_o)
  );

  assign armed_o   = flags.armed;
  assign waiting_o = flags.waiting;

  assert_wake_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> armed_o);
endmodule

// File: tb/addr_monitor_wake_bench.sv
module addr_monitor_wake_bench;
  localparam int AW = 48;

  typedef struct packed {
    logic          arm;
    logic [AW-1:0] vaddr;
    logic          wt;
    logic [AW-1:0] paddr;
    logic          snp;
    logic [AW-1:0] saddr;
    logic          e_sleep;
    logic          e_wake;
    logic          e_armed;
    logic          e_wait;
    logic [AW-1:0] e_line;
    logic [6:0]    e_span;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // idle after reset (R1)
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b0, 48'h0, 1'b0, 1'b0, 1'b0, 1'b0, 48'h0, 7'd64},
    // arm aligned address (R2, R9)
    '{1'b1, 48'h1000, 1'b0, 48'h0, 1'b0, 48'h0, 1'b0, 1'b0, 1'b1, 1'b0, 48'h0, 7'd64},
    // wait masks the line and sleeps (R3, R10)
    '{1'b0, 48'h0, 1'b1, 48'h2345, 1'b0, 48'h0, 1'b1, 1'b0, 1'b1, 1'b1, 48'h2340, 7'd64},
    // unaligned snoop is not an exact match (R5, R7)
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 48'h2345, 1'b0, 1'b0, 1'b1, 1'b1, 48'h2340, 7'd64},
    // neighbouring line (R7)
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 48'h2380, 1'b0, 1'b0, 1'b1, 1'b1, 48'h2340, 7'd64},
    // hit wakes and ends the wait (R5, R6)
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 48'h2340, 1'b0, 1'b1, 1'b1, 1'b0, 48'h2340, 7'd64},
    // pending wakeup: wait returns at once, line kept, pulse is over (R4, R6, R10)
    '{1'b0, 48'h0, 1'b1, 48'h5000, 1'b0, 48'h0, 1'b0, 1'b0, 1'b1, 1'b0, 48'h2340, 7'd64},
    // pending consumed, next wait sleeps (R3, R4)
    '{1'b0, 48'h0, 1'b1, 48'h5010, 1'b0, 48'h0, 1'b1, 1'b0, 1'b1, 1'b1, 48'h5000, 7'd64},
    // old line no longer matches (R7)
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 48'h2340, 1'b0, 1'b0, 1'b1, 1'b1, 48'h5000, 7'd64},
    // wait and snoop of the new line together: wait first (R8)
    '{1'b0, 48'h0, 1'b1, 48'h6000, 1'b1, 48'h6000, 1'b1, 1'b1, 1'b1, 1'b0, 48'h6000, 7'd64},
    // re-arm unaligned clears the line (R2, R9)
    '{1'b1, 48'h3007, 1'b0, 48'h0, 1'b0, 48'h0, 1'b0, 1'b0, 1'b1, 1'b0, 48'h0, 7'd57},
    // wakeup from the row before still pending (R4)
    '{1'b0, 48'h0, 1'b1, 48'h7000, 1'b0, 48'h0, 1'b0, 1'b0, 1'b1, 1'b0, 48'h0, 7'd57},
    // wait sleeps on 0x7000 (R3)
    '{1'b0, 48'h0, 1'b1, 48'h7000, 1'b0, 48'h0, 1'b1, 1'b0, 1'b1, 1'b1, 48'h7000, 7'd57},
    // arm while waiting: line to 0, waiting kept (R2)
    '{1'b1, 48'h8000, 1'b0, 48'h0, 1'b0, 48'h0, 1'b0, 1'b0, 1'b1, 1'b1, 48'h0, 7'd64},
    // snoop of address 0 matches the cleared line (R5, R6)
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 48'h0, 1'b0, 1'b1, 1'b1, 1'b0, 48'h0, 7'd64}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm_valid = 1'b0;
  logic [AW-1:0] arm_vaddr = '0;
  logic          wait_valid = 1'b0;
  logic [AW-1:0] wait_paddr = '0;
  logic          wait_sleep;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          wake;
  logic          armed;
  logic          waiting;
  logic [AW-1:0] mon_line;
  logic [AW-1:0] armed_vaddr;
  logic [6:0]    span;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_monitor_wake u_addr_monitor_wake (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm_valid_i   (arm_valid),
    .arm_vaddr_i   (arm_vaddr),
    .wait_valid_i  (wait_valid),
    .wait_paddr_i  (wait_paddr),
    .wait_sleep_o  (wait_sleep),
    .snoop_valid_i (snoop_valid),
    .snoop_addr_i  (snoop_addr),
    .wake_o        (wake),
    .armed_o       (armed),
    .waiting_o     (waiting),
    .mon_line_o    (mon_line),
    .armed_vaddr_o (armed_vaddr),
    .span_bytes_o  (span)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic [AW-1:0] va, input logic w,
                       input logic [AW-1:0] pa, input logic s, input logic [AW-1:0] sa);
    @(negedge clk);
    arm_valid = a; arm_vaddr = va;
    wait_valid = w; wait_paddr = pa;
    snoop_valid = s; snoop_addr = sa;
    #1;
  endtask

  task automatic step_edge;
    @(posedge clk);
    #1;
    arm_valid = 1'b0; wait_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 armed in reset", 64'(armed), 64'd0);
    chk("R1 waiting in reset", 64'(waiting), 64'd0);
    chk("R1 wake in reset", 64'(wake), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].arm, VEC[i].vaddr, VEC[i].wt, VEC[i].paddr, VEC[i].snp, VEC[i].saddr);
      if (VEC[i].wt) chk($sformatf("R10 table %0d sleep", i), 64'(wait_sleep), 64'(VEC[i].e_sleep));
      step_edge();
      chk($sformatf("R6 table %0d wake", i), 64'(wake), 64'(VEC[i].e_wake));
      chk($sformatf("R2 table %0d armed", i), 64'(armed), 64'(VEC[i].e_armed));
      chk($sformatf("R3 table %0d waiting", i), 64'(waiting), 64'(VEC[i].e_wait));
      chk($sformatf("R3 table %0d line", i), 64'(mon_line), 64'(VEC[i].e_line));
      chk($sformatf("R9 table %0d span", i), 64'(span), 64'(VEC[i].e_span));
    end

    // R1: fresh reset clears pending; then R7: unarmed monitor ignores a matching snoop
    @(negedge clk); rst_n = 1'b0;
    step_edge();
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, '0, 1'b1, 48'h40, 1'b0, '0);
    chk("R1 no pending after reset", 64'(wait_sleep), 64'd1);
    step_edge();
    chk("R1 armed stays low", 64'(armed), 64'd0);
    drive(1'b0, '0, 1'b0, '0, 1'b1, 48'h40);
    step_edge();
    chk("R7 unarmed snoop no wake", 64'(wake), 64'd0);
    chk("R7 unarmed snoop keeps waiting", 64'(waiting), 64'd1);
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0);
    chk("R10 no strobe no sleep", 64'(wait_sleep), 64'd0);
    step_edge();

    // R9: last byte of a line gives a span of one
    drive(1'b1, 48'h103F, 1'b0, '0, 1'b0, '0);
    step_edge();
    chk("R9 span at offset 63", 64'(span), 64'd1);
    chk("R2 vaddr stored", 64'(armed_vaddr), 64'h103F);

    // R8: arm and snoop of 0 in the same cycle hit the cleared line (still waiting)
    drive(1'b1, 48'h2000, 1'b0, '0, 1'b1, 48'h0);
    step_edge();
    chk("R8 arm before snoop wakes", 64'(wake), 64'd1);
    chk("R8 waiting cleared", 64'(waiting), 64'd0);
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0);
    step_edge();
    chk("R6 pulse is single", 64'(wake), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule